// File: doc/BRIEF.md
# Channel Command Sequencer

This block is the control core of an I/O data channel. Once the unit is selected and a load request arrives with the address of a command, it fetches a 36-bit command word from memory. The command gives a transfer direction, a chaining choice, a word count and a starting memory address. The block then moves that many words between a device port and consecutive memory locations, one word at a time. When the count reaches zero it either fetches the command that follows in memory or disconnects and raises a completion pulse toward the CPU.

Memory is reached through a request/acknowledge port: a request holds until it is acknowledged, and read data is taken in the acknowledge cycle. The device side has a valid/ready port for each direction. A busy output serves the CPU as a test condition while a command list is running.

Top module: `chan_cmd_ctrl`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, mem_req_o, dev_in_ready_o and dev_out_valid_o are all low.
- R2: A load request (start_i) is accepted only while idle and while sel_i is high. The first memory request that follows is a read at start_addr_i. A load request without sel_i, or one made while busy, has no effect.
- R3: Command word bits are numbered 0 (word[35]) to 35 (word[0]). Bits 0-2 (word[35:33]) form the operation code, bits 3-17 (word[32:18]) the word count and bits 21-35 (word[14:0]) the start address. Bits 18-20 (word[17:15]) are ignored.
- R4: Operation code bit 0 (word[35]) = 1 selects input (device to memory) and 0 selects output (memory to device). Bit 2 (word[33]) = 1 selects chaining and 0 selects disconnect. Bit 1 (word[34]) has no effect.
- R5: The words of one command use ascending consecutive addresses from the command's start address, wrapping modulo 2^15.
- R6: Exactly "count" words are moved, and the word counter drops by one for each word.
- R7: On input, a word is taken when dev_in_ready_o and dev_in_valid_i are both high. It is then written to memory with that same data at the current address.
- R8: On output, the word at the current address is read and then presented on dev_out_data_o. dev_out_valid_o and the data are held until dev_out_ready_i.
- R9: A memory request keeps its address, write flag and write data unchanged until mem_ack_i.
- R10: A command with a count of zero moves no words. It goes straight to chaining or to disconnect.
- R11: After each fetch, the command location advances by one. Chaining fetches from the next consecutive location, wrapping modulo 2^15.
- R12: On disconnect, done_o pulses for one cycle. busy_o is high from the cycle after acceptance through the done_o cycle and is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Unit is selected |
| start_i | input | 1 | Load-command request |
| start_addr_i | input | 15 | Address of the first command |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 15 | Memory address |
| mem_wdata_o | output | 36 | Write data |
| mem_ack_i | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata_i | input | 36 | Read data |
| dev_in_valid_i | input | 1 | Device offers an input word |
| dev_in_data_i | input | 36 | Input word |
| dev_in_ready_o | output | 1 | Channel takes an input word |
| dev_out_valid_o | output | 1 | Output word is presented |
| dev_out_data_o | output | 36 | Output word |
| dev_out_ready_i | input | 1 | Device takes the output word |
| busy_o | output | 1 | Command list is running |
| done_o | output | 1 | One-cycle disconnect pulse |

## Verification
The hardest situations to reach are a command list that mixes directions, carries zero-count links and wraps both the data address and the command location past the top of memory. Equally hard is a load request that arrives in the middle of such a list. The stimulus builds these lists in the bench memory, some with the ignored opcode and address bits set. It stalls the memory acknowledge and both device handshakes with a pseudo-random pattern, so that hold behaviour is exercised in every state. A behavioural model walks the same list to predict every memory access and every device word in order.

// File: rtl/chan_pkg.sv
package chan_pkg;

  localparam int CH_WORD_W = 36;
  localparam int CH_OP_W   = 3;
  localparam int CH_CNT_W  = 15;
  localparam int CH_ADDR_W = 15;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECIDE,
    ST_DEV_IN,
    ST_MEM_WR,
    ST_MEM_RD,
    ST_DEV_OUT,
    ST_DISC
  } chan_state_t;

endpackage

// File: rtl/chan_regs.sv
module chan_regs #(
  parameter int WORD_W = 36,
  parameter int OP_W   = 3,
  parameter int CNT_W  = 15,
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_clc,
  input  logic [ADDR_W-1:0] clc_in,
  input  logic              ld_cmd,
  input  logic [OP_W-1:0]   op_in,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              word_done,
  input  logic              data_ld,
  input  logic [WORD_W-1:0] data_in,
  output logic [OP_W-1:0]   op_q,
  output logic [CNT_W-1:0]  wc_q,
  output logic [ADDR_W-1:0] cac_q,
  output logic [ADDR_W-1:0] clc_q,
  output logic [WORD_W-1:0] dreg_q
);

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] count_next(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  // command location counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        clc_q <= '0;
    else if (load_clc) clc_q <= clc_in;
    else if (ld_cmd)   clc_q <= addr_next(clc_q);
  end

  // operation register, word counter, channel address counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      wc_q  <= '0;
      cac_q <= '0;
    end else if (ld_cmd) begin
      op_q  <= op_in;
      wc_q  <= cnt_in;
      cac_q <= addr_in;
    end else if (word_done) begin
      wc_q  <= count_next(wc_q);
      cac_q <= addr_next(cac_q);
    end
  end

  // data register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dreg_q <= '0;
    else if (data_ld) dreg_q <= data_in;
  end

endmodule

// File: rtl/chan_seq.sv
module chan_seq #(
  parameter int CNT_W = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_i,
  input  logic                  start_i,
  input  logic                  mem_ack_i,
  input  logic                  dev_in_valid_i,
  input  logic                  dev_out_ready_i,
  input  logic                  op_dir_in,
  input  logic                  op_chain,
  input  logic [CNT_W-1:0]      wc_q,
  output chan_pkg::chan_state_t state_q,
  output logic                  ev_accept,
  output logic                  ev_fetch_done,
  output logic                  ev_in_take,
  output logic                  ev_rd_done,
  output logic                  ev_word_done
);
  import chan_pkg::*;

  chan_state_t state_d;
  logic        ev_wr_done;
  logic        ev_out_take;
  logic        cnt_zero;

  assign cnt_zero      = (wc_q == '0);
  assign ev_accept     = (state_q == ST_IDLE)    && sel_i && start_i;
  assign ev_fetch_done = (state_q == ST_FETCH)   && mem_ack_i;
  assign ev_in_take    = (state_q == ST_DEV_IN)  && dev_in_valid_i;
  assign ev_wr_done    = (state_q == ST_MEM_WR)  && mem_ack_i;
  assign ev_rd_done    = (state_q == ST_MEM_RD)  && mem_ack_i;
  assign ev_out_take   = (state_q == ST_DEV_OUT) && dev_out_ready_i;
  assign ev_word_done  = ev_wr_done || ev_out_take;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (ev_accept)     state_d = ST_FETCH;
      ST_FETCH:   if (ev_fetch_done) state_d = ST_DECIDE;
      ST_DECIDE: begin
        if (cnt_zero)       state_d = op_chain ? ST_FETCH : ST_DISC;
        else if (op_dir_in) state_d = ST_DEV_IN;
        else                state_d = ST_MEM_RD;
      end
      ST_DEV_IN:  if (ev_in_take)    state_d = ST_MEM_WR;
      ST_MEM_WR:  if (ev_wr_done)    state_d = ST_DECIDE;
      ST_MEM_RD:  if (ev_rd_done)    state_d = ST_DEV_OUT;
      ST_DEV_OUT: if (ev_out_take)   state_d = ST_DECIDE;
      ST_DISC:                       state_d = ST_IDLE;
      default:                       state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/chan_port.sv
module chan_port #(
  parameter int WORD_W = 36,
  parameter int ADDR_W = 15
) (
  input  chan_pkg::chan_state_t state_q,
  input  logic [ADDR_W-1:0]     clc_q,
  input  logic [ADDR_W-1:0]     cac_q,
  input  logic [WORD_W-1:0]     dreg_q,
  output logic                  mem_req_o,
  output logic                  mem_we_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [WORD_W-1:0]     mem_wdata_o,
  output logic                  dev_in_ready_o,
  output logic                  dev_out_valid_o,
  output logic [WORD_W-1:0]     dev_out_data_o,
  output logic                  busy_o,
  output logic                  done_o
);
  import chan_pkg::*;

  logic st_fetch;

  assign st_fetch        = (state_q == ST_FETCH);
  assign mem_req_o       = st_fetch || (state_q == ST_MEM_WR) || (state_q == ST_MEM_RD);
  assign mem_we_o        = (state_q == ST_MEM_WR);
  assign mem_addr_o      = st_fetch ? clc_q : cac_q;
  assign mem_wdata_o     = dreg_q;
  assign dev_in_ready_o  = (state_q == ST_DEV_IN);
  assign dev_out_valid_o = (state_q == ST_DEV_OUT);
  assign dev_out_data_o  = dreg_q;
  assign busy_o          = (state_q != ST_IDLE);
  assign done_o          = (state_q == ST_DISC);

endmodule

// File: rtl/chan_cmd_ctrl.sv
module chan_cmd_ctrl #(
  parameter int WORD_W = chan_pkg::CH_WORD_W,
  parameter int OP_W   = chan_pkg::CH_OP_W,
  parameter int CNT_W  = chan_pkg::CH_CNT_W,
  parameter int ADDR_W = chan_pkg::CH_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              dev_in_valid_i,
  input  logic [WORD_W-1:0] dev_in_data_i,
  output logic              dev_in_ready_o,
  output logic              dev_out_valid_o,
  output logic [WORD_W-1:0] dev_out_data_o,
  input  logic              dev_out_ready_i,
  output logic              busy_o,
  output logic              done_o
);
  import chan_pkg::*;

  localparam int OP_LSB  = WORD_W - OP_W;
  localparam int CNT_LSB = OP_LSB - CNT_W;

  chan_state_t       state_q;
  logic              ev_accept, ev_fetch_done, ev_in_take, ev_rd_done, ev_word_done;
  logic [OP_W-1:0]   op_q;
  logic [CNT_W-1:0]  wc_q;
  logic [ADDR_W-1:0] cac_q, clc_q;
  logic [WORD_W-1:0] dreg_q;
  logic [OP_W-1:0]   cmd_op;
  logic [CNT_W-1:0]  cmd_cnt;
  logic [ADDR_W-1:0] cmd_addr;
  logic [WORD_W-1:0] data_src;

  assign cmd_op   = mem_rdata_i[WORD_W-1:OP_LSB];
  assign cmd_cnt  = mem_rdata_i[OP_LSB-1:CNT_LSB];
  assign cmd_addr = mem_rdata_i[ADDR_W-1:0];
  assign data_src = ev_in_take ? dev_in_data_i : mem_rdata_i;

  chan_seq #(.CNT_W(CNT_W)) u_seq (
    .clk             (clk),
    .rst_n           (rst_n),
    .sel_i           (sel_i),
    .start_i         (start_i),
    .mem_ack_i       (mem_ack_i),
    .dev_in_valid_i  (dev_in_valid_i),
    .dev_out_ready_i (dev_out_ready_i),
    .op_dir_in       (op_q[OP_W-1]),
    .op_chain        (op_q[0]),
    .wc_q            (wc_q),
    .state_q         (state_q),
    .ev_accept       (ev_accept),
    .ev_fetch_done   (ev_fetch_done),
    .ev_in_take      (ev_in_take),
    .ev_rd_done      (ev_rd_done),
    .ev_word_done    (ev_word_done)
  );

  chan_regs #(.WORD_W(WORD_W), .OP_W(OP_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_clc  (ev_accept),
    .clc_in    (start_addr_i),
    .ld_cmd    (ev_fetch_done),
    .op_in     (cmd_op),
    .cnt_in    (cmd_cnt),
    .addr_in   (cmd_addr),
    .word_done (ev_word_done),
    .data_ld   (ev_in_take || ev_rd_done),
    .data_in   (data_src),
    .op_q      (op_q),
    .wc_q      (wc_q),
    .cac_q     (cac_q),
    .clc_q     (clc_q),
    .dreg_q    (dreg_q)
  );

  chan_port #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_port (
    .state_q         (state_q),
    .clc_q           (clc_q),
    .cac_q           (cac_q),
    .dreg_q          (dreg_q),
    .mem_req_o       (mem_req_o),
    .mem_we_o        (mem_we_o),
    .mem_addr_o      (mem_addr_o),
    .mem_wdata_o     (mem_wdata_o),
    .dev_in_ready_o  (dev_in_ready_o),
    .dev_out_valid_o (dev_out_valid_o),
    .dev_out_data_o  (dev_out_data_o),
    .busy_o          (busy_o),
    .done_o          (done_o)
  );

endmodule

// File: rtl/chan_cmd_ctrl_chk.sv
module chan_cmd_ctrl_chk #(
  parameter int WORD_W = 36,
  parameter int OP_W   = 3,
  parameter int CNT_W  = 15,
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [WORD_W-1:0] mem_wdata_o,
  input logic              mem_ack_i,
  input logic              dev_in_valid_i,
  input logic [WORD_W-1:0] dev_in_data_i,
  input logic              dev_in_ready_o,
  input logic              dev_out_valid_o,
  input logic [WORD_W-1:0] dev_out_data_o,
  input logic              dev_out_ready_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              ev_accept,
  input logic              ev_fetch_done,
  input logic              ev_word_done,
  input logic [OP_W-1:0]   op_q,
  input logic [CNT_W-1:0]  wc_q,
  input logic [ADDR_W-1:0] cac_q,
  input logic [ADDR_W-1:0] clc_q
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !dev_in_ready_o && !dev_out_valid_o && !done_o);

  p_accept_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy_o && mem_req_o && !mem_we_o && (mem_addr_o == $past(start_addr_i)));

  p_op_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_in_ready_o || dev_out_valid_o || mem_we_o) |-> $stable(op_q));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word_done |=> (cac_q - $past(cac_q)) == ADDR_W'(1));

  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word_done |=> ($past(wc_q) - wc_q) == CNT_W'(1));

  p_in_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_in_ready_o && dev_in_valid_i) |=> mem_req_o && mem_we_o && (mem_wdata_o == $past(dev_in_data_i)));

  p_one_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_o, dev_in_ready_o, dev_out_valid_o}));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_out_valid_o && !dev_out_ready_i) |=> dev_out_valid_o && $stable(dev_out_data_o));

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  p_clc_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch_done |=> (clc_q - $past(clc_q)) == ADDR_W'(1));

  p_done_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o && !done_o);

endmodule

bind chan_cmd_ctrl chan_cmd_ctrl_chk #(
  .WORD_W(WORD_W), .OP_W(OP_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_addr_i    (start_addr_i),
  .mem_req_o       (mem_req_o),
  .mem_we_o        (mem_we_o),
  .mem_addr_o      (mem_addr_o),
  .mem_wdata_o     (mem_wdata_o),
  .mem_ack_i       (mem_ack_i),
  .dev_in_valid_i  (dev_in_valid_i),
  .dev_in_data_i   (dev_in_data_i),
  .dev_in_ready_o  (dev_in_ready_o),
  .dev_out_valid_o (dev_out_valid_o),
  .dev_out_data_o  (dev_out_data_o),
  .dev_out_ready_i (dev_out_ready_i),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .ev_accept       (ev_accept),
  .ev_fetch_done   (ev_fetch_done),
  .ev_word_done    (ev_word_done),
  .op_q            (op_q),
  .wc_q            (wc_q),
  .cac_q           (cac_q),
  .clc_q           (clc_q)
);

// File: tb/tb_chan_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_chan_cmd_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_i = 1'b0, start_i = 1'b0;
  logic [14:0] start_addr_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [14:0] mem_addr_o;
  logic [35:0] mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [35:0] mem_rdata_i = '0;
  logic        dev_in_valid_i = 1'b0;
  logic [35:0] dev_in_data_i = '0;
  logic        dev_in_ready_o, dev_out_valid_o;
  logic [35:0] dev_out_data_o;
  logic        dev_out_ready_i = 1'b0;
  logic        busy_o, done_o;

  always #2.5 clk = ~clk;

  chan_cmd_ctrl dut (.*);

  typedef struct packed { logic we; logic [14:0] addr; logic [35:0] data; } acc_t;

  logic [35:0] bmem [0:32767];
  acc_t        exp_mem [$];
  string       exp_tag [$];
  logic [35:0] exp_out [$];
  logic [35:0] in_q [$];

  int    checks = 0, failures = 0, cyc = 0, done_cnt = 0;
  bit    prog_active = 0, finished = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [35:0] pat = 36'h5_1234_0000;
  bit    req_pend = 0, out_pend = 0;
  logic [51:0] req_snap;
  logic [35:0] out_snap;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R3/R4 encoding: [35] input, [34] ignored, [33] chain, [32:18] count, [17:15] ignored, [14:0] address
  function automatic logic [35:0] mk_cmd(input bit dir_in, input bit chain, input bit junk1,
                                         input logic [14:0] cnt, input logic [2:0] junk,
                                         input logic [14:0] addr);
    return {dir_in, junk1, chain, cnt, junk, addr};
  endfunction

  // behavioural walk of the command list
  task automatic build_expect(input logic [14:0] first);
    logic [14:0] loc;
    loc = first;
    for (int n = 0; n < 32; n++) begin
      logic [35:0] w;
      logic [14:0] ad;
      w  = bmem[loc];
      exp_mem.push_back('{we: 1'b0, addr: loc, data: '0});
      exp_tag.push_back("R11");
      loc = loc + 15'd1;
      ad = w[14:0];
      for (int k = 0; k < int'(w[32:18]); k++) begin
        if (w[35]) begin
          pat = pat + 36'h0_0101_0103;
          in_q.push_back(pat);
          exp_mem.push_back('{we: 1'b1, addr: ad, data: pat});
          exp_tag.push_back("R7");
        end else begin
          exp_mem.push_back('{we: 1'b0, addr: ad, data: '0});
          exp_tag.push_back("R5");
          exp_out.push_back(bmem[ad]);
        end
        ad = ad + 15'd1;
      end
      if (!w[33]) break;
    end
  endtask

  // memory and device responder, plus per-cycle comparisons
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (cyc > 150000 && !finished) begin
      finished = 1;
      chk(0, "watchdog", 64'(cyc), 64'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
    if (!rst_n) begin
      mem_ack_i = 0; dev_in_valid_i = 0; dev_out_ready_i = 0;
    end else begin
      if (req_pend)
        chk(mem_req_o && {mem_we_o, mem_addr_o, mem_wdata_o} == req_snap, "R9 request hold",
            64'({mem_we_o, mem_addr_o, mem_wdata_o}), 64'(req_snap));
      mem_ack_i = 0;
      req_pend = 0;
      if (mem_req_o) begin
        if (lfsr[0] | lfsr[3]) begin
          acc_t e;
          string t;
          mem_ack_i = 1;
          mem_rdata_i = bmem[mem_addr_o];
          if (mem_we_o) bmem[mem_addr_o] = mem_wdata_o;
          if (exp_mem.size() == 0) begin
            chk(0, "R2 unexpected memory access", 64'(mem_addr_o), 64'd0);
          end else begin
            e = exp_mem.pop_front();
            t = exp_tag.pop_front();
            chk(mem_addr_o == e.addr && mem_we_o == e.we && (!e.we || mem_wdata_o == e.data), t,
                64'({mem_we_o, mem_addr_o, mem_wdata_o}), 64'(e));
          end
        end else begin
          req_pend = 1;
          req_snap = {mem_we_o, mem_addr_o, mem_wdata_o};
        end
      end
      dev_in_valid_i = 0;
      if (dev_in_ready_o && in_q.size() > 0 && (lfsr[2] | lfsr[7])) begin
        dev_in_valid_i = 1;
        dev_in_data_i = in_q.pop_front();
      end
      if (out_pend)
        chk(dev_out_valid_o && dev_out_data_o == out_snap, "R8 output hold",
            64'(dev_out_data_o), 64'(out_snap));
      dev_out_ready_i = 0;
      out_pend = 0;
      if (dev_out_valid_o) begin
        if (lfsr[1] | lfsr[5]) begin
          dev_out_ready_i = 1;
          if (exp_out.size() == 0) chk(0, "R8 unexpected output word", 64'(dev_out_data_o), 64'd0);
          else chk(dev_out_data_o == exp_out[0], "R8 output data", 64'(dev_out_data_o), 64'(exp_out[0]));
          if (exp_out.size() > 0) void'(exp_out.pop_front());
        end else begin
          out_pend = 1;
          out_snap = dev_out_data_o;
        end
      end
      if (prog_active) chk(busy_o == 1'b1, "R12 busy during list", 64'(busy_o), 64'd1);
      if (done_o) begin
        done_cnt++;
        chk(exp_mem.size() == 0 && exp_out.size() == 0, "R6 all words moved at disconnect",
            64'(exp_mem.size() + exp_out.size()), 64'd0);
      end
    end
  end

  task automatic run_list(input logic [14:0] first, input bit poke);
    int target;
    target = done_cnt + 1;
    build_expect(first);
    @(negedge clk);
    sel_i = 1; start_i = 1; start_addr_i = first;
    @(negedge clk);
    start_i = 0;
    chk(busy_o == 1'b1, "R2 busy after accept", 64'(busy_o), 64'd1);
    prog_active = 1;
    if (poke) begin
      repeat (6) @(negedge clk);
      start_i = 1; start_addr_i = 15'h0064;   // R2: must be ignored while busy
      @(negedge clk);
      start_i = 0;
    end
    wait (done_cnt == target);
    prog_active = 0;
    @(negedge clk);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R12 idle after done", 64'({busy_o, done_o}), 64'd0);
    chk(exp_mem.size() == 0 && in_q.size() == 0, "R10 no extra traffic",
        64'(exp_mem.size() + in_q.size()), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 32768; i++) bmem[i] = 36'(i) * 36'h0_0000_1357 + 36'h7_0000_0000;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o && !dev_in_ready_o && !dev_out_valid_o, "R1 reset state",
        64'({busy_o, done_o, mem_req_o, dev_in_ready_o, dev_out_valid_o}), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy_o && !mem_req_o, "R1 idle after reset release", 64'({busy_o, mem_req_o}), 64'd0);

    // R2: request without selection
    sel_i = 0; start_i = 1; start_addr_i = 15'h0100;
    @(negedge clk);
    start_i = 0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !mem_req_o, "R2 start without select ignored", 64'({busy_o, mem_req_o}), 64'd0);

    // single output, disconnect
    bmem[15'h0100] = mk_cmd(0, 0, 0, 15'd3, 3'b000, 15'h0200);
    run_list(15'h0100, 0);
    // single input, disconnect
    bmem[15'h0120] = mk_cmd(1, 0, 0, 15'd4, 3'b000, 15'h0300);
    run_list(15'h0120, 0);
    // R3 R4 R10 R11: chained list with ignored bits set and zero-count links
    bmem[15'h0140] = mk_cmd(1, 1, 1, 15'd2, 3'b101, 15'h0400);
    bmem[15'h0141] = mk_cmd(0, 1, 1, 15'd3, 3'b111, 15'h0500);
    bmem[15'h0142] = mk_cmd(0, 1, 0, 15'd0, 3'b000, 15'h0600);
    bmem[15'h0143] = mk_cmd(1, 0, 1, 15'd0, 3'b010, 15'h0700);
    run_list(15'h0140, 0);
    // R5: data address wrap
    bmem[15'h0160] = mk_cmd(0, 0, 0, 15'd3, 3'b000, 15'h7FFE);
    run_list(15'h0160, 0);
    // R2: load request while busy ignored
    bmem[15'h0180] = mk_cmd(1, 1, 0, 15'd5, 3'b000, 15'h0800);
    bmem[15'h0181] = mk_cmd(0, 0, 0, 15'd4, 3'b000, 15'h0900);
    run_list(15'h0180, 1);
    // R11: command location wrap
    bmem[15'h7FFF] = mk_cmd(0, 1, 0, 15'd0, 3'b000, 15'h0000);
    bmem[15'h0000] = mk_cmd(0, 0, 0, 15'd2, 3'b000, 15'h0210);
    run_list(15'h7FFF, 0);
    // R6 R7: longer input burst
    bmem[15'h01A0] = mk_cmd(1, 0, 0, 15'd20, 3'b000, 15'h0A00);
    run_list(15'h01A0, 0);

    chk(done_cnt == 7, "R12 done pulse count", 64'(done_cnt), 64'd7);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule